// File: doc/BRIEF.md
# Capture Timer

An 8-bit up-counter with a compare register and an input-capture register. The counter advances on a tick chosen from seven prescaler taps on the system clock or from an external clock pin. When it reaches the compare value it raises a match flag and restarts from zero. In capture mode, a selected edge on the capture pin copies the live count into the capture register and sets a capture flag.

Software sees four byte registers. Compare and capture share one address: a read returns the captured count and a write loads the compare value. The counter restarts on every match, so software can measure a pulse longer than one counter period. It counts match interrupts and adds the final captured count.

Top module: `cap_timer`

## Requirements
- R1: After reset all registers read 0, the counter is 0, and irq_match_o, irq_cap_o and tmr_out_o are low.
- R2: When the enable bit is 1, the counter increments by one at each clock edge where the selected tick is present. When the enable bit is 0, the counter holds its value.
- R3: A tick that finds the counter equal to the compare value sets the counter to 0 and sets the match flag, instead of incrementing.
- R4: Clock select codes 0..6 pick the system clock divided by 2, 4, 8, 32, 128, 512 and 2048. The prescaler is an 11-bit counter that runs freely from reset. Divide-by-2^k ticks in the cycle where the low k bits of that counter are all ones, that is, when the number of cycles since reset is congruent to 2^k-1 modulo 2^k.
- R5: Clock select code 7 takes ticks from ext_clk_i. The input passes through two flops, and a rising edge becomes a one-cycle tick. The count changes at the third clock edge after the pin rises.
- R6: In capture mode (mode bit 5 of the control register set), a selected capture-pin edge copies the counter value held before that edge into the capture register and sets the capture flag. The edge is detected after the same two-flop delay as R5. When mode bit 5 is clear, capture-pin edges do not change the capture register.
- R7: Polarity bit 4 of register 2 selects the capture edge: 1 selects rising, 0 selects falling.
- R8: Writing register 0 with bit 0 set clears the counter at that edge, even when a tick or match occurs in the same cycle, and suppresses the match. Bit 0 always reads back as 0.
- R9: Register map:
  - address 0: control register. Bit 7 is enable, bit 6 reads 0, bits 5:4 are mode, bits 3:1 are clock select, bit 0 is the clear strobe.
  - address 1: a read returns the capture register, and a write loads the compare register.
  - address 2: interrupt register. Bit 0 is the match flag, bit 1 is the capture flag, bit 2 is the match interrupt enable, bit 3 is the capture interrupt enable, bit 4 is the polarity, and bits 7:5 read 0.
  - address 3: reads the counter. Writes to it are ignored.
- R10: A flag is cleared by writing 1 to its bit in register 2 or by pulsing its acknowledge input. A set event in the same cycle wins over a clear. irq_match_o is the match flag AND its enable, and irq_cap_o is the capture flag AND its enable.
- R11: Outside capture mode, tmr_out_o toggles on each match. In capture mode it is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| ext_clk_i | input | 1 | External tick source |
| cap_i | input | 1 | Capture input pin |
| irq_ack_match_i | input | 1 | Clears the match flag |
| irq_ack_cap_i | input | 1 | Clears the capture flag |
| irq_match_o | output | 1 | Match interrupt request |
| irq_cap_o | output | 1 | Capture interrupt request |
| tmr_out_o | output | 1 | Timer output, held low in capture mode |

## Verification
Register writes, clear strobes, acknowledges and prescaler ticks take effect at the next clock edge. Pin events on ext_clk_i and cap_i take effect at the third edge after the pin changes. The bench keeps a reference model that steps once per rising edge, with its own prescaler count and pin delay lines. It compares the model with the read data, both interrupt lines and the timer output 2 ns after every edge. The bench drives inputs at the falling edge, so both the design and the model see the same values at each rising edge.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_IRQ  = 2'd2,
    ADDR_CNT  = 2'd3
  } reg_addr_e;

  localparam int unsigned NUM_TAPS = 7;
  localparam logic [2:0] SEL_EXT = 3'd7;

  // log2 of the division ratio for each prescaler tap
  function automatic int unsigned tap_shift(logic [2:0] sel);
    case (sel)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 7;
      3'd5: return 9;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/cap_timer_sync_edge.sv
module cap_timer_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

  a_r5_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cap_timer_prescale.sv
module cap_timer_prescale
  import cap_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_rise_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [7:0]       tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int unsigned SH = tap_shift(3'(g));
    assign tap[g] = &div_q[SH-1:0];
  end
  assign tap[7] = ext_rise_i;

  assign tick_o = tap[sel_i];

  a_r4_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap[0] |=> !tap[0]);
endmodule

// File: rtl/cap_timer_core.sv
module cap_timer_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             capmode_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             cap_edge_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             match_o,
  output logic             capt_o
);
  logic [CNT_W-1:0] cnt_q, cap_q;
  logic             step;

  assign step    = en_i & tick_i & ~clr_i;
  assign match_o = step & (cnt_q == cmp_i);
  assign capt_o  = capmode_i & cap_edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (match_o) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (capt_o) cap_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

  a_r2_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  a_r3_step_or_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  a_r6_no_capture_outside_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capmode_i |=> $stable(cap_q));
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 11,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_we_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             ext_clk_i,
  input  logic             cap_i,
  input  logic             irq_ack_match_i,
  input  logic             irq_ack_cap_i,
  output logic             irq_match_o,
  output logic             irq_cap_o,
  output logic             tmr_out_o
);
  logic             en_q;
  logic [1:0]       mode_q;
  logic [2:0]       sel_q;
  logic [CNT_W-1:0] cmp_q;
  logic             mflag_q, cflag_q, mie_q, cie_q, pol_q, tog_q;

  logic wr_ctrl, wr_data, wr_irq, clr_strobe, clr_m, clr_c;
  logic ext_rise, ext_fall, cap_rise, cap_fall, cap_edge, tick;
  logic match, capt;
  logic [CNT_W-1:0] cnt, cap;
  logic unused_bits;

  assign wr_ctrl    = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_data    = reg_we_i && (reg_addr_i == ADDR_DATA);
  assign wr_irq     = reg_we_i && (reg_addr_i == ADDR_IRQ);
  assign clr_strobe = wr_ctrl && reg_wdata_i[0];
  assign clr_m      = (wr_irq && reg_wdata_i[0]) || irq_ack_match_i;
  assign clr_c      = (wr_irq && reg_wdata_i[1]) || irq_ack_cap_i;
  assign unused_bits = ^{reg_wdata_i[CNT_W-1:5], reg_wdata_i[6], ext_fall};

  cap_timer_sync_edge #(.STAGES(SYNC_N)) u_ext_sync (
    .clk_i, .rst_ni, .pin_i(ext_clk_i), .rise_o(ext_rise), .fall_o(ext_fall));

  cap_timer_sync_edge #(.STAGES(SYNC_N)) u_cap_sync (
    .clk_i, .rst_ni, .pin_i(cap_i), .rise_o(cap_rise), .fall_o(cap_fall));

  assign cap_edge = pol_q ? cap_rise : cap_fall;

  cap_timer_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .sel_i(sel_q), .ext_rise_i(ext_rise), .tick_o(tick));

  cap_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .en_i(en_q), .capmode_i(mode_q[1]), .tick_i(tick), .clr_i(clr_strobe),
    .cap_edge_i(cap_edge), .cmp_i(cmp_q),
    .cnt_o(cnt), .cap_o(cap), .match_o(match), .capt_o(capt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; mode_q <= '0; sel_q <= '0; cmp_q <= '0;
      mie_q <= 1'b0; cie_q <= 1'b0; pol_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= reg_wdata_i[7];
        mode_q <= reg_wdata_i[5:4];
        sel_q  <= reg_wdata_i[3:1];
      end
      if (wr_data) cmp_q <= reg_wdata_i;
      if (wr_irq) begin
        mie_q <= reg_wdata_i[2];
        cie_q <= reg_wdata_i[3];
        pol_q <= reg_wdata_i[4];
      end
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mflag_q <= 1'b0; cflag_q <= 1'b0; tog_q <= 1'b0;
    end else begin
      if (match)      mflag_q <= 1'b1;
      else if (clr_m) mflag_q <= 1'b0;
      if (capt)       cflag_q <= 1'b1;
      else if (clr_c) cflag_q <= 1'b0;
      if (match && !mode_q[1]) tog_q <= ~tog_q;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {en_q, 1'b0, mode_q, sel_q, 1'b0};
      ADDR_DATA: reg_rdata_o = cap;
      ADDR_IRQ:  reg_rdata_o = {3'b000, pol_q, cie_q, mie_q, cflag_q, mflag_q};
      default:   reg_rdata_o = cnt;
    endcase
  end

  assign irq_match_o = mflag_q & mie_q;
  assign irq_cap_o   = cflag_q & cie_q;
  assign tmr_out_o   = tog_q & ~mode_q[1];

  a_r8_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_strobe |=> (cnt == '0));
  a_r10_mflag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mflag_q && !clr_m) |=> mflag_q);
  a_r10_cflag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cflag_q && !clr_c) |=> cflag_q);
  a_r11_out_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] && $past(mode_q[1])) |-> $stable(tog_q));
endmodule

// File: tb/cap_timer_bench.sv
module cap_timer_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = 2'd3;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic       ext = 1'b0, cap = 1'b0, ack_m = 1'b0, ack_c = 1'b0;
  logic [7:0] rdata;
  logic       irq_m, irq_c, tout;

  int checks = 0, errors = 0;
  bit running = 0, done = 0;
  string ph = "R2";
  logic [1:0] view = 2'd3;

  always #5 clk = ~clk;

  cap_timer u_cap_timer (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ext_clk_i(ext), .cap_i(cap),
    .irq_ack_match_i(ack_m), .irq_ack_cap_i(ack_c),
    .irq_match_o(irq_m), .irq_cap_o(irq_c), .tmr_out_o(tout));

  // reference model
  int unsigned m_pc;
  bit [7:0] m_cnt, m_cmp, m_cap;
  bit       m_en, m_mf, m_cf, m_mie, m_cie, m_pol, m_tog;
  bit [1:0] m_mode;
  bit [2:0] m_sel, m_es, m_cs;

  function automatic int div_log(bit [2:0] s);
    int t[7] = '{1, 2, 3, 5, 7, 9, 11};
    return t[s];
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pc = 0; m_cnt = 0; m_cmp = 0; m_cap = 0; m_en = 0; m_mf = 0; m_cf = 0;
      m_mie = 0; m_cie = 0; m_pol = 0; m_tog = 0; m_mode = 0; m_sel = 0;
      m_es = 0; m_cs = 0;
    end else begin : step
      bit tk, ce, clr, mt;
      bit [7:0] old_cnt;
      int p;
      if (m_sel == 3'd7) tk = m_es[1] & ~m_es[2];
      else begin
        p = 1 << div_log(m_sel);
        tk = ((m_pc % p) == p - 1);
      end
      ce = m_pol ? (m_cs[1] & ~m_cs[2]) : (~m_cs[1] & m_cs[2]);
      clr = we && addr == 2'd0 && wdata[0];
      mt = !clr && m_en && tk && m_cnt == m_cmp;
      old_cnt = m_cnt;
      if (clr || mt) m_cnt = 0;
      else if (m_en && tk) m_cnt = m_cnt + 1;
      if (m_mode[1] && ce) begin m_cap = old_cnt; m_cf = 1; end
      else if ((we && addr == 2'd2 && wdata[1]) || ack_c) m_cf = 0;
      if (mt) m_mf = 1;
      else if ((we && addr == 2'd2 && wdata[0]) || ack_m) m_mf = 0;
      if (mt && !m_mode[1]) m_tog = ~m_tog;
      if (we && addr == 2'd0) begin m_en = wdata[7]; m_mode = wdata[5:4]; m_sel = wdata[3:1]; end
      if (we && addr == 2'd1) m_cmp = wdata;
      if (we && addr == 2'd2) begin m_mie = wdata[2]; m_cie = wdata[3]; m_pol = wdata[4]; end
      m_pc = (m_pc + 1) % 2048;
      m_es = {m_es[1:0], ext};
      m_cs = {m_cs[1:0], cap};
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] exp_rd(bit [1:0] a);
    case (a)
      2'd0: return {m_en, 1'b0, m_mode, m_sel, 1'b0};
      2'd1: return m_cap;
      2'd2: return {3'b000, m_pol, m_cie, m_mie, m_cf, m_mf};
      default: return m_cnt;
    endcase
  endfunction

  // per-cycle comparison
  always @(posedge clk) begin
    #2;
    if (running && rst_ni) begin
      case (addr)
        2'd0: chk("R8 ctrl read", rdata, exp_rd(addr));
        2'd1: chk("R9/R6 capture read", rdata, exp_rd(addr));
        2'd2: chk("R10 irq reg read", rdata, exp_rd(addr));
        default: chk({ph, " count"}, rdata, exp_rd(addr));
      endcase
      chk("R10 irq_match", irq_m, m_mf & m_mie);
      chk("R10 irq_cap", irq_c, m_cf & m_cie);
      chk("R11/R3 tmr_out", tout, m_tog & ~m_mode[1]);
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = view;
  endtask

  task automatic idle(input bit [1:0] a, input int n);
    @(negedge clk); view = a; addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cap(input int gap, input int wid);
    repeat (gap) @(negedge clk);
    cap = 1; repeat (wid) @(negedge clk); cap = 0;
  endtask

  task automatic ack(input bit which);
    @(negedge clk); if (which) ack_c = 1; else ack_m = 1;
    @(negedge clk); ack_c = 0; ack_m = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk("R1 reset read", rdata, 0);
    end
    chk("R1 reset irq_match", irq_m, 0);
    chk("R1 reset irq_cap", irq_c, 0);
    chk("R1 reset tmr_out", tout, 0);
    addr = 2'd3;
    @(negedge clk); rst_ni = 1; running = 1;

    // R2/R3: divide by 2, compare 5, timer mode
    ph = "R2";
    wr(2'd1, 8'd5);
    wr(2'd2, 8'h1C);
    wr(2'd0, 8'h80);
    idle(2'd3, 40);
    idle(2'd2, 6);
    ph = "R3";
    ack(0);
    idle(2'd3, 20);
    wr(2'd2, 8'h1D);
    idle(2'd2, 8);

    // R4: prescaler taps
    ph = "R4";
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h86);
    idle(2'd3, 400);
    wr(2'd0, 8'h84);
    idle(2'd3, 200);
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h8C);
    idle(2'd3, 5000);

    // R5: external clock
    ph = "R5";
    wr(2'd1, 8'd4);
    wr(2'd0, 8'h8E);
    idle(2'd3, 2);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); ext = ~ext;
      repeat (2) @(negedge clk);
    end
    idle(2'd3, 6);

    // R6: capture mode, rising edge
    ph = "R6";
    wr(2'd1, 8'd200);
    wr(2'd0, 8'hA1);
    idle(2'd1, 1);
    for (int i = 0; i < 5; i++) pulse_cap(7 + 3 * i, 4);
    idle(2'd1, 6);
    idle(2'd2, 2);
    ack(1);

    // R7: falling polarity
    ph = "R7";
    wr(2'd2, 8'h0C);
    idle(2'd1, 1);
    for (int i = 0; i < 4; i++) pulse_cap(9, 2 + i);
    idle(2'd1, 6);
    wr(2'd2, 8'h1E);
    idle(2'd2, 4);

    // R8: clear strobe, including collision with a tick
    ph = "R8";
    wr(2'd0, 8'hA1);
    idle(2'd0, 3);
    idle(2'd3, 5);
    wr(2'd1, 8'd2);
    for (int i = 0; i < 6; i++) wr(2'd0, 8'h81);
    idle(2'd3, 12);

    // R2: hold while disabled
    ph = "R2";
    wr(2'd0, 8'h20);
    idle(2'd3, 20);

    // R6: no capture outside capture mode; R9 write to address 3 ignored
    ph = "R6";
    wr(2'd0, 8'h80);
    wr(2'd3, 8'hFF);
    idle(2'd1, 1);
    pulse_cap(4, 3);
    pulse_cap(4, 3);
    idle(2'd1, 6);
    ph = "R11";
    wr(2'd1, 8'd3);
    idle(2'd3, 30);
    wr(2'd0, 8'hB0);
    idle(2'd3, 30);
    wr(2'd0, 8'h80);
    idle(2'd3, 20);

    running = 0;
    finish_run();
  end
endmodule